// File: doc/BRIEF.md
# Multicast Time-Slot Interchange Switch

This block is the switching core of a router node in an on-chip network that carries circuit-switched traffic in fixed time-division frames. It has a configurable number of ports. The default is five: four mesh neighbours plus the local resource. Each frame holds a fixed number of word slots.

Every input owns two frame buffers. The input link fills one of them while the transfer engine drains the other. Every output also owns two frame buffers. The output link reads one of them while the transfer engine fills the other. One frame-start pulse exchanges the roles of all of these buffers.

The transfer engine walks a slot map table one row per clock cycle. It uses a separate table for each output. A valid entry in a row names an input port, a slot of that input's drained buffer, and a destination slot in that output's fill buffer. Several outputs may copy the same input word in the same row, which gives multicast.

Each output's table is double-buffered. Configuration writes always land in the shadow copy, which becomes active at the next frame start. An input buffer has one read port, so a row that asks the same input for two different slots is a contention error. The block flags that row and still serves it from the request of the lowest-numbered output.

Top module: `tdm_mcast_switch`

## Requirements
- R1: While reset is applied and right after it, `busy` and `slotClash` are 0 and every output reads 0 at every slot.
- R2: A `frameStart` pulse swaps, on one edge, the written and drained input buffers, the read and filled output buffers, and the active and shadow tables. A word written on the input link during one frame is moved during the next frame and can be read at the output during the frame after that.
- R3: After the edge that samples `frameStart`, `busy` is 1 for exactly ROWS cycles. Row r of the active tables executes on the (r+1)-th edge after that sample, so the last row, ROWS-1, is executed too.
- R4: For a valid entry of output o in the current row, the word at slot `is` of input `ib` is written to slot `os` of output o's fill buffer.
- R5: When several outputs in one row name the same input and slot, each of them receives that word at its own destination slot.
- R6: An entry is a no-operation if its valid bit is 0 or if its input number is not below PORTS. The destination location then keeps its earlier content.
- R7: When a row names the same input with two different slot numbers, `slotClash` is 1 in the cycle after that row executes. Every output reading that input in that row receives the slot chosen by the lowest-numbered requesting output. `slotClash` is 0 whenever the previous cycle was not part of a transfer phase.
- R8: A configuration write goes only to the shadow table of port `cfgPort`. Writes to a port at or above PORTS, or to a row at or above ROWS, are dropped. A write made during a transfer phase does not change that phase's transfers, and it takes effect after the next `frameStart`. Tables are not cleared when they swap.
- R9: Between two `frameStart` pulses, the word read at an output for an unchanged `outRdSlot` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Frame boundary pulse: swap banks and start the transfer phase |
| inWrEn | input | PORTS | Input link write enable, one bit per input |
| inWrSlot | input | PORTS*SB | Slot written by each input link (field i at bits i*SB) |
| inWrData | input | PORTS*WIDTH | Word written by each input link (field i at bits i*WIDTH) |
| outRdSlot | input | PORTS*SB | Slot read by each output link |
| outRdData | output | PORTS*WIDTH | Word read from each output's read buffer |
| cfgWrEn | input | 1 | Shadow table write strobe |
| cfgPort | input | PB | Output whose shadow table is written |
| cfgRow | input | RB | Row written |
| cfgValid | input | 1 | Valid bit of the entry |
| cfgInPort | input | PB | Source input number |
| cfgInSlot | input | SB | Source slot |
| cfgOutSlot | input | SB | Destination slot |
| busy | output | 1 | Transfer phase in progress |
| slotClash | output | 1 | Previous row had a read-port contention |

## Verification
Two things can happen in the same cycle here. The transfer engine reads the active table row while a configuration write lands in the shadow table of the same output. The bench writes a conflicting entry into the shadow copy in the middle of a transfer phase. It then expects the frame results to follow only the old table, and the new entry to act only in the following frame. Within one row, multicast fan-out and read-port contention also coincide. A row where three outputs name one input, one of them at a different slot, is judged by the cycle in which `slotClash` rises and by the words each destination receives.

// File: rtl/tdmsw_pkg.sv
`timescale 1ns/1ps
package tdmsw_pkg;
  // Control to datapath strobes
  typedef struct packed {
    logic run;   // a table row is executed this cycle
    logic bank;  // current bank selector (link side)
  } tdmswStrobe_t;
endpackage

// File: rtl/tdmsw_ctrl.sv
`timescale 1ns/1ps
module tdmsw_ctrl
  import tdmsw_pkg::*;
#(
  parameter int ROWS = 10,
  localparam int RB = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frameStart,
  output tdmswStrobe_t  strobe,
  output logic [RB-1:0] rowIdx,
  output logic          busy
);
  logic bankQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bankQ  <= 1'b0;
      rowIdx <= '0;
      busy   <= 1'b0;
    end else if (frameStart) begin
      bankQ  <= ~bankQ;
      rowIdx <= '0;
      busy   <= 1'b1;
    end else if (busy) begin
      if (rowIdx == RB'(ROWS - 1)) busy <= 1'b0;
      else rowIdx <= rowIdx + 1'b1;
    end
  end

  assign strobe.run  = busy;
  assign strobe.bank = bankQ;
endmodule

// File: rtl/tdmsw_slotmap.sv
`timescale 1ns/1ps
module tdmsw_slotmap
  import tdmsw_pkg::*;
#(
  parameter int PORTS = 5,
  parameter int SLOTS = 8,
  parameter int ROWS  = 10,
  localparam int PB = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int SB = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int RB = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tdmswStrobe_t        strobe,
  input  logic [RB-1:0]       rowIdx,
  input  logic                cfgWrEn,
  input  logic [PB-1:0]       cfgPort,
  input  logic [RB-1:0]       cfgRow,
  input  logic                cfgValid,
  input  logic [PB-1:0]       cfgInPort,
  input  logic [SB-1:0]       cfgInSlot,
  input  logic [SB-1:0]       cfgOutSlot,
  output logic [PORTS-1:0]    rowValid,
  output logic [PORTS*PB-1:0] rowIb,
  output logic [PORTS*SB-1:0] rowIs,
  output logic [PORTS*SB-1:0] rowOs
);
  logic          tValid [2][PORTS][ROWS];
  logic [PB-1:0] tIb    [2][PORTS][ROWS];
  logic [SB-1:0] tIs    [2][PORTS][ROWS];
  logic [SB-1:0] tOs    [2][PORTS][ROWS];

  logic cfgHit;
  assign cfgHit = cfgWrEn && (int'(cfgPort) < PORTS) && (int'(cfgRow) < ROWS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < PORTS; p++)
          for (int r = 0; r < ROWS; r++) begin
            tValid[b][p][r] <= 1'b0;
            tIb[b][p][r]    <= '0;
            tIs[b][p][r]    <= '0;
            tOs[b][p][r]    <= '0;
          end
    end else if (cfgHit) begin
      tValid[~strobe.bank][cfgPort][cfgRow] <= cfgValid;
      tIb[~strobe.bank][cfgPort][cfgRow]    <= cfgInPort;
      tIs[~strobe.bank][cfgPort][cfgRow]    <= cfgInSlot;
      tOs[~strobe.bank][cfgPort][cfgRow]    <= cfgOutSlot;
    end
  end

  // Active row lookup, one entry per output
  for (genvar o = 0; o < PORTS; o++) begin : g_row
    logic rowOk;
    assign rowOk                 = int'(rowIdx) < ROWS;
    assign rowValid[o]           = rowOk && tValid[strobe.bank][o][rowIdx];
    assign rowIb[o*PB +: PB]     = rowOk ? tIb[strobe.bank][o][rowIdx] : '0;
    assign rowIs[o*SB +: SB]     = rowOk ? tIs[strobe.bank][o][rowIdx] : '0;
    assign rowOs[o*SB +: SB]     = rowOk ? tOs[strobe.bank][o][rowIdx] : '0;
  end
endmodule

// File: rtl/tdmsw_datapath.sv
`timescale 1ns/1ps
module tdmsw_datapath
  import tdmsw_pkg::*;
#(
  parameter int PORTS = 5,
  parameter int SLOTS = 8,
  parameter int WIDTH = 8,
  localparam int PB = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int SB = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tdmswStrobe_t           strobe,
  input  logic [PORTS-1:0]       inWrEn,
  input  logic [PORTS*SB-1:0]    inWrSlot,
  input  logic [PORTS*WIDTH-1:0] inWrData,
  input  logic [PORTS*SB-1:0]    outRdSlot,
  output logic [PORTS*WIDTH-1:0] outRdData,
  input  logic [PORTS-1:0]       rowValid,
  input  logic [PORTS*PB-1:0]    rowIb,
  input  logic [PORTS*SB-1:0]    rowIs,
  input  logic [PORTS*SB-1:0]    rowOs,
  output logic                   slotClash
);
  logic [WIDTH-1:0] inBuf  [2][PORTS][SLOTS];
  logic [WIDTH-1:0] outBuf [2][PORTS][SLOTS];

  logic [PB-1:0]    ibOf     [PORTS];
  logic [SB-1:0]    isOf     [PORTS];
  logic [SB-1:0]    osOf     [PORTS];
  logic [PORTS-1:0] useEnt;
  logic [SB-1:0]    grantSlot [PORTS];
  logic [PORTS-1:0] grantHit;
  logic [PORTS-1:0] clashIn;
  logic [WIDTH-1:0] rdWord   [PORTS];

  always_comb begin
    for (int o = 0; o < PORTS; o++) begin
      ibOf[o]   = rowIb[o*PB +: PB];
      isOf[o]   = rowIs[o*SB +: SB];
      osOf[o]   = rowOs[o*SB +: SB];
      useEnt[o] = rowValid[o] && (int'(ibOf[o]) < PORTS) && (int'(osOf[o]) < SLOTS)
                  && (int'(isOf[o]) < SLOTS);
    end
  end

  // Single read port per input: lowest-numbered requesting output picks the slot
  always_comb begin
    for (int i = 0; i < PORTS; i++) begin
      grantSlot[i] = '0;
      grantHit[i]  = 1'b0;
      clashIn[i]   = 1'b0;
      for (int o = 0; o < PORTS; o++) begin
        if (useEnt[o] && int'(ibOf[o]) == i) begin
          if (!grantHit[i]) begin
            grantHit[i]  = 1'b1;
            grantSlot[i] = isOf[o];
          end else if (isOf[o] != grantSlot[i]) begin
            clashIn[i] = 1'b1;
          end
        end
      end
    end
  end

  // Fully connected crossbar
  always_comb begin
    for (int o = 0; o < PORTS; o++)
      rdWord[o] = useEnt[o] ? inBuf[~strobe.bank][ibOf[o]][grantSlot[ibOf[o]]] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < PORTS; p++)
          for (int s = 0; s < SLOTS; s++) begin
            inBuf[b][p][s]  <= '0;
            outBuf[b][p][s] <= '0;
          end
      slotClash <= 1'b0;
    end else begin
      for (int i = 0; i < PORTS; i++)
        if (inWrEn[i] && int'(inWrSlot[i*SB +: SB]) < SLOTS)
          inBuf[strobe.bank][i][inWrSlot[i*SB +: SB]] <= inWrData[i*WIDTH +: WIDTH];
      if (strobe.run)
        for (int o = 0; o < PORTS; o++)
          if (useEnt[o]) outBuf[~strobe.bank][o][osOf[o]] <= rdWord[o];
      slotClash <= strobe.run && (|clashIn);
    end
  end

  for (genvar o = 0; o < PORTS; o++) begin : g_rd
    logic [SB-1:0] rs;
    assign rs = outRdSlot[o*SB +: SB];
    assign outRdData[o*WIDTH +: WIDTH] =
      (int'(rs) < SLOTS) ? outBuf[strobe.bank][o][rs] : '0;
  end
endmodule

// File: rtl/tdm_mcast_switch.sv
`timescale 1ns/1ps
module tdm_mcast_switch
  import tdmsw_pkg::*;
#(
  parameter int PORTS = 5,
  parameter int SLOTS = 8,
  parameter int ROWS  = 10,
  parameter int WIDTH = 8,
  localparam int PB = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int SB = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int RB = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frameStart,
  input  logic [PORTS-1:0]       inWrEn,
  input  logic [PORTS*SB-1:0]    inWrSlot,
  input  logic [PORTS*WIDTH-1:0] inWrData,
  input  logic [PORTS*SB-1:0]    outRdSlot,
  output logic [PORTS*WIDTH-1:0] outRdData,
  input  logic                   cfgWrEn,
  input  logic [PB-1:0]          cfgPort,
  input  logic [RB-1:0]          cfgRow,
  input  logic                   cfgValid,
  input  logic [PB-1:0]          cfgInPort,
  input  logic [SB-1:0]          cfgInSlot,
  input  logic [SB-1:0]          cfgOutSlot,
  output logic                   busy,
  output logic                   slotClash
);
  tdmswStrobe_t        strobe;
  logic [RB-1:0]       rowIdx;
  logic [PORTS-1:0]    rowValid;
  logic [PORTS*PB-1:0] rowIb;
  logic [PORTS*SB-1:0] rowIs;
  logic [PORTS*SB-1:0] rowOs;

  tdmsw_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart),
    .strobe(strobe), .rowIdx(rowIdx), .busy(busy)
  );

  tdmsw_slotmap #(.PORTS(PORTS), .SLOTS(SLOTS), .ROWS(ROWS)) u_map (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rowIdx(rowIdx),
    .cfgWrEn(cfgWrEn), .cfgPort(cfgPort), .cfgRow(cfgRow), .cfgValid(cfgValid),
    .cfgInPort(cfgInPort), .cfgInSlot(cfgInSlot), .cfgOutSlot(cfgOutSlot),
    .rowValid(rowValid), .rowIb(rowIb), .rowIs(rowIs), .rowOs(rowOs)
  );

  tdmsw_datapath #(.PORTS(PORTS), .SLOTS(SLOTS), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .inWrEn(inWrEn), .inWrSlot(inWrSlot), .inWrData(inWrData),
    .outRdSlot(outRdSlot), .outRdData(outRdData),
    .rowValid(rowValid), .rowIb(rowIb), .rowIs(rowIs), .rowOs(rowOs),
    .slotClash(slotClash)
  );
endmodule

// File: rtl/tdm_mcast_switch_chk.sv
`timescale 1ns/1ps
module tdm_mcast_switch_chk #(
  parameter int PORTS = 5,
  parameter int SLOTS = 8,
  parameter int ROWS  = 10,
  parameter int WIDTH = 8,
  localparam int SB = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CB = $clog2(ROWS + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frameStart,
  input logic [PORTS*SB-1:0]    outRdSlot,
  input logic [PORTS*WIDTH-1:0] outRdData,
  input logic                   busy,
  input logic                   slotClash
);
  // Independent phase counter: cycles elapsed since the last frame start
  logic [CB-1:0] phaseCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phaseCnt <= CB'(ROWS);
    else if (frameStart) phaseCnt <= '0;
    else if (int'(phaseCnt) < ROWS) phaseCnt <= phaseCnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !slotClash));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> busy);

  assert_phase_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (int'(phaseCnt) < ROWS));

  assert_clash_in_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slotClash |-> $past(busy));

  assert_read_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |=> (!$stable(outRdSlot) || $stable(outRdData)));
endmodule

bind tdm_mcast_switch tdm_mcast_switch_chk #(
  .PORTS(PORTS), .SLOTS(SLOTS), .ROWS(ROWS), .WIDTH(WIDTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .outRdSlot(outRdSlot),
  .outRdData(outRdData), .busy(busy), .slotClash(slotClash)
);

// File: tb/tdm_mcast_switch_bench.sv
`timescale 1ns/1ps
module tdm_mcast_switch_bench;
  localparam int PORTS = 5, SLOTS = 8, ROWS = 10, WIDTH = 8;
  localparam int PB = 3, SB = 3, RB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameStart = 1'b0;
  logic [PORTS-1:0] inWrEn = '0;
  logic [PORTS*SB-1:0] inWrSlot = '0;
  logic [PORTS*WIDTH-1:0] inWrData = '0;
  logic [PORTS*SB-1:0] outRdSlot = '0;
  logic [PORTS*WIDTH-1:0] outRdData;
  logic cfgWrEn = 1'b0, cfgValid = 1'b0;
  logic [PB-1:0] cfgPort = '0, cfgInPort = '0;
  logic [RB-1:0] cfgRow = '0;
  logic [SB-1:0] cfgInSlot = '0, cfgOutSlot = '0;
  logic busy, slotClash;

  int nChk = 0, nBad = 0;
  bit done = 0;

  typedef struct { int port; int slot; int val; string req; } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  tdm_mcast_switch u_tdm_mcast_switch (.*);

  function automatic int wordOf(int i, int s, int tag);
    return i * 32 + s * 4 + tag;
  endfunction

  task automatic checkVal(string req, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushExp(int port, int slot, int val, string req);
    expItem_t it;
    it.port = port; it.slot = slot; it.val = val; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor side: pops expected words and compares against the read port
  task automatic drainExp();
    while (expQ.size() > 0) begin
      expItem_t it = expQ.pop_front();
      outRdSlot[it.port*SB +: SB] = SB'(it.slot);
      #1;
      checkVal(it.req, int'(outRdData[it.port*WIDTH +: WIDTH]), it.val);
    end
  endtask

  task automatic cfgWrite(int port, int row, bit v, int ib, int is, int os);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgPort = PB'(port); cfgRow = RB'(row); cfgValid = v;
    cfgInPort = PB'(ib); cfgInSlot = SB'(is); cfgOutSlot = SB'(os);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic fillInputs(int tag);
    for (int s = 0; s < SLOTS; s++) begin
      @(negedge clk);
      inWrEn = '1;
      for (int i = 0; i < PORTS; i++) begin
        inWrSlot[i*SB +: SB] = SB'(s);
        inWrData[i*WIDTH +: WIDTH] = WIDTH'(wordOf(i, s, tag));
      end
    end
    @(negedge clk);
    inWrEn = '0;
  endtask

  task automatic pulseFrame();
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkVal("R1 busy", int'(busy), 0);
    checkVal("R1 slotClash", int'(slotClash), 0);
    checkVal("R1 outRdData", int'(|outRdData), 0);
    rst_n = 1'b1;
    @(negedge clk);
    checkVal("R1 busy after release", int'(busy), 0);

    // Frame 0 data into input bank 0, tables into shadow bank
    fillInputs(0);
    cfgWrite(0, 0, 1, 2, 5, 1);                       // R4
    cfgWrite(1, 1, 1, 4, 3, 0);                       // R5 multicast
    cfgWrite(2, 1, 1, 4, 3, 6);
    cfgWrite(3, 1, 1, 4, 3, 7);
    cfgWrite(4, 2, 1, 0, 7, 7);                       // R4 edge slots
    cfgWrite(0, 2, 1, 3, 0, 0);
    cfgWrite(2, 3, 1, 1, 2, 3);                       // R7 clash row
    cfgWrite(3, 3, 1, 1, 5, 4);
    cfgWrite(4, 3, 1, 1, 2, 1);
    cfgWrite(3, 4, 0, 0, 0, 5);                       // R6 invalid bit
    cfgWrite(3, 5, 1, 6, 0, 6);                       // R6 input number out of range
    cfgWrite(1, ROWS - 1, 1, 1, 6, 2);                // R3 last row
    cfgWrite(7, 0, 1, 0, 0, 4);                       // R8 port out of range dropped

    // Frame A: transfers run; check phase length, clash timing, shadow write, stable read
    outRdSlot[0*SB +: SB] = SB'(1);
    pulseFrame();
    for (int k = 0; k <= ROWS; k++) begin
      checkVal($sformatf("R3 busy k=%0d", k), int'(busy), (k < ROWS) ? 1 : 0);
      checkVal($sformatf("R7 slotClash k=%0d", k), int'(slotClash), (k == 4) ? 1 : 0);
      checkVal($sformatf("R9 read stable k=%0d", k), int'(outRdData[0 +: WIDTH]), 0);
      if (k == 2) begin
        cfgWrEn = 1'b1; cfgPort = '0; cfgRow = '0; cfgValid = 1'b1;
        cfgInPort = '0; cfgInSlot = '0; cfgOutSlot = SB'(1);     // R8 shadow write during phase
      end else cfgWrEn = 1'b0;
      @(negedge clk);
    end
    fillInputs(1);

    // Frame B: results of frame A visible
    pushExp(0, 1, wordOf(2, 5, 0), "R4 single copy");
    pushExp(0, 0, wordOf(3, 0, 0), "R4 second row same output");
    pushExp(1, 0, wordOf(4, 3, 0), "R5 multicast out1");
    pushExp(2, 6, wordOf(4, 3, 0), "R5 multicast out2");
    pushExp(3, 7, wordOf(4, 3, 0), "R5 multicast out3");
    pushExp(4, 7, wordOf(0, 7, 0), "R4 last slot");
    pushExp(1, 2, wordOf(1, 6, 0), "R3 last row executed");
    pushExp(2, 3, wordOf(1, 2, 0), "R7 clash winner");
    pushExp(3, 4, wordOf(1, 2, 0), "R7 clash loser gets winner slot");
    pushExp(4, 1, wordOf(1, 2, 0), "R7 same slot share");
    pushExp(3, 5, 0, "R6 invalid entry no-op");
    pushExp(3, 6, 0, "R6 out-of-range input no-op");
    pushExp(4, 4, 0, "R8 write to absent port dropped");
    pulseFrame();
    checkVal("R2 frame B busy", int'(busy), 1);
    drainExp();
    repeat (ROWS + 2) @(negedge clk);

    // Frame C: the shadow write made during frame A now acted on frame-B-moved data
    pushExp(0, 1, wordOf(0, 0, 1), "R8 shadow entry effective next frame");
    pushExp(2, 3, 0, "R6 untouched location keeps content");
    pushExp(0, 0, 0, "R2 other bank independent");
    pulseFrame();
    drainExp();
    repeat (ROWS + 2) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule